// File: doc/BRIEF.md
# Push-Button Duty Stepper with PWM Output

This block drives one pulse-width modulated line from the system clock. The PWM period is the system clock rate divided by the output rate. Both rates are parameters, and so is the duty setting after reset. With the defaults (50 MHz clock, 1 kHz output) one period is 50000 cycles, and the output starts with a duty of two tenths. Setting the parameters for a 1 Hz output with an initial duty of five tenths gives the slow variant. Rates cannot change while the block runs.

A push button and a direction switch change the duty while the block runs. Each clean press moves the setting by one tenth, in the direction the switch selects. The setting stops at zero and at ten tenths. Both inputs are synchronised first. The button then passes a debounce filter of about 10 ms, and its rising edge becomes a single step request. A new setting is shown on the duty output at once, but the PWM output only uses it from the start of the next period. No period is ever cut short or stretched.

Top module: `pwm_step_gen`

## Requirements
- R1: The output repeats every PERIOD = CLK_HZ/PWM_HZ cycles. In each period it is high for floor(PERIOD*d/10) cycles and low for the rest, where d is the duty setting in use for that period.
- R2: While reset is asserted, duty_o equals DUTY_INIT and pwm_o is low. After reset is released, the period counter starts again from zero.
- R3: When the synchronised direction switch is 1, an accepted press raises duty_o by exactly one.
- R4: When the synchronised direction switch is 0, an accepted press lowers duty_o by exactly one.
- R5: duty_o never goes above 10 or below 0. At 10 the output stays high for a whole period, and at 0 it stays low for a whole period.
- R6: A change of the synchronised button level that lasts fewer than DEBOUNCE_CYCLES cycles is ignored and does not step the duty.
- R7: A press gives exactly one step, on its debounced rising edge. Holding the button and releasing it give no further step.
- R8: A changed duty setting reaches the PWM output only at the start of the next period. The period that is running keeps its old high time.
- R9: With the default parameters the output period is 50000 cycles and the high time is 10000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_i | input | 1 | Raw push button, active high, may bounce |
| dir_i | input | 1 | Direction switch: 1 steps up, 0 steps down |
| pwm_o | output | 1 | PWM output, registered |
| duty_o | output | 4 | Current duty setting in tenths, 0 to 10 |

## Verification
The bench goes after the saturation edges. A design that wrapped past 10 or below 0 would jump to a very low or a very high duty instead of staying full on or full off. It sends button bursts shorter than the debounce window. A filter that reacted to the first edge would step once per bounce. It holds the button well past the debounce time. A level-triggered stepper would then move the duty again and again. A reference model, checked every cycle, catches a duty value loaded in the middle of a period, which shows up as a runt pulse. A separate instance built with the default parameters confirms the 50000-cycle period with its 10000-cycle high time.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;
  localparam int unsigned TENTHS_FULL = 10;

  typedef logic [3:0] tenth_t;

  // Number of high cycles within a period for a given duty in tenths
  function automatic int unsigned on_cycles(input int unsigned period,
                                            input int unsigned tenths);
    return (period * tenths) / TENTHS_FULL;
  endfunction
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;
endmodule

// File: rtl/pwm_btn_cond.sv
module pwm_btn_cond #(
  parameter int unsigned DB_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  input  logic dir_i,
  output logic press_o,
  output logic up_o
);
  localparam int unsigned DW = (DB_CYCLES > 1) ? $clog2(DB_CYCLES + 1) : 1;
  localparam logic [DW-1:0] DB_LAST = DW'(DB_CYCLES - 1);

  logic btn_s1_q, btn_s2_q;
  logic dir_s1_q, dir_s2_q;
  logic          stab_q, stab_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          press_q, press_d;

  // Debounce: the synchronised level must differ for DB_CYCLES edges
  always_comb begin
    stab_d  = stab_q;
    dcnt_d  = dcnt_q;
    press_d = 1'b0;
    if (btn_s2_q != stab_q) begin
      if (dcnt_q == DB_LAST) begin
        stab_d  = btn_s2_q;
        dcnt_d  = '0;
        press_d = btn_s2_q;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end else begin
      dcnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_s1_q <= 1'b0;
      btn_s2_q <= 1'b0;
      dir_s1_q <= 1'b0;
      dir_s2_q <= 1'b0;
      stab_q   <= 1'b0;
      dcnt_q   <= '0;
      press_q  <= 1'b0;
    end else begin
      btn_s1_q <= btn_i;
      btn_s2_q <= btn_s1_q;
      dir_s1_q <= dir_i;
      dir_s2_q <= dir_s1_q;
      stab_q   <= stab_d;
      dcnt_q   <= dcnt_d;
      press_q  <= press_d;
    end
  end

  assign press_o = press_q;
  assign up_o    = dir_s2_q;
endmodule

// File: rtl/pwm_duty_step.sv
module pwm_duty_step
  import pwm_step_pkg::*;
#(
  parameter int unsigned DUTY_INIT = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   press_i,
  input  logic   up_i,
  output tenth_t duty_o
);
  localparam tenth_t TOP  = tenth_t'(TENTHS_FULL);
  localparam tenth_t INIT = tenth_t'(DUTY_INIT);

  tenth_t duty_q, duty_d;
  logic   duty_en;

  always_comb begin
    duty_d  = duty_q;
    duty_en = 1'b0;
    if (press_i) begin
      if (up_i && (duty_q < TOP)) begin
        duty_d  = duty_q + 1'b1;
        duty_en = 1'b1;
      end else if (!up_i && (duty_q != '0)) begin
        duty_d  = duty_q - 1'b1;
        duty_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= INIT;
    end else if (duty_en) begin
      duty_q <= duty_d;
    end
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_period_cmp.sv
module pwm_period_cmp
  import pwm_step_pkg::*;
#(
  parameter int unsigned PERIOD    = 50000,
  parameter int unsigned DUTY_INIT = 2,
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int unsigned TW = $clog2(PERIOD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tenth_t        duty_i,
  output logic          pwm_o,
  output logic [CW-1:0] cnt_o,
  output tenth_t        act_o
);
  localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);

  logic [TW-1:0] thr_tab [16];

  // Compare thresholds, one per possible code; codes above full saturate
  for (genvar g = 0; g < 16; g++) begin : g_thr
    localparam int unsigned TN = (g > TENTHS_FULL) ? TENTHS_FULL : g;
    assign thr_tab[g] = TW'(on_cycles(PERIOD, TN));
  end

  logic [CW-1:0] cnt_q, cnt_d;
  tenth_t        act_q, act_d;
  logic          pwm_q, pwm_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CNT_LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    act_d = wrap ? duty_i : act_q;
    pwm_d = (TW'(cnt_q) < thr_tab[act_q]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= tenth_t'(DUTY_INIT);
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
      if (wrap) begin
        act_q <= act_d;
      end
    end
  end

  assign pwm_o = pwm_q;
  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwm_step_gen.sv
module pwm_step_gen
  import pwm_step_pkg::*;
#(
  parameter int unsigned CLK_HZ          = 50000000,
  parameter int unsigned PWM_HZ          = 1000,
  parameter int unsigned DUTY_INIT       = 2,
  parameter int unsigned DEBOUNCE_CYCLES = CLK_HZ / 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_i,
  input  logic       dir_i,
  output logic       pwm_o,
  output logic [3:0] duty_o
);
  localparam int unsigned PERIOD = CLK_HZ / PWM_HZ;
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic          rst_int_n;
  logic          press_w;
  logic          up_w;
  tenth_t        duty_w;
  tenth_t        act_w;
  logic [CW-1:0] cnt_w;

  pwm_rst_sync u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_int_n)
  );

  pwm_btn_cond #(.DB_CYCLES(DEBOUNCE_CYCLES)) u_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .btn_i  (btn_i),
    .dir_i  (dir_i),
    .press_o(press_w),
    .up_o   (up_w)
  );

  pwm_duty_step #(.DUTY_INIT(DUTY_INIT)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .press_i(press_w),
    .up_i   (up_w),
    .duty_o (duty_w)
  );

  pwm_period_cmp #(.PERIOD(PERIOD), .DUTY_INIT(DUTY_INIT)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .duty_i(duty_w),
    .pwm_o (pwm_o),
    .cnt_o (cnt_w),
    .act_o (act_w)
  );

  assign duty_o = duty_w;
endmodule

// File: rtl/pwm_step_chk.sv
module pwm_step_chk #(
  parameter int unsigned PERIOD = 50000,
  parameter int unsigned CW     = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    duty,
  input logic [3:0]    act,
  input logic [CW-1:0] cnt,
  input logic          press,
  input logic          pwm
);
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CW'(PERIOD - 1)) |=> (cnt == '0)); // R1

  AST_DUTY_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty <= 4'd10)); // R5

  AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty != $past(duty)) |-> ((duty == $past(duty) + 4'd1) || (duty + 4'd1 == $past(duty)))); // R3

  AST_STEP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty != $past(duty)) |-> $past(press)); // R7

  AST_LOAD_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act != $past(act)) |-> (cnt == '0)); // R8

  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == 4'd10) |=> pwm); // R5

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == 4'd0) |=> !pwm); // R5
endmodule

bind pwm_step_gen pwm_step_chk #(.PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_int_n),
  .duty  (duty_w),
  .act   (act_w),
  .cnt   (cnt_w),
  .press (press_w),
  .pwm   (pwm_o)
);

// File: tb/pwm_step_gen_tb.sv
module pwm_step_gen_tb;
  localparam int CLK_HZ = 2500;
  localparam int PWM_HZ = 100;
  localparam int P      = CLK_HZ / PWM_HZ;
  localparam int INIT   = 2;
  localparam int DB     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic dir = 1'b0;
  logic pwm_o, def_pwm;
  logic [3:0] duty_o, def_duty;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_step_gen #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .DUTY_INIT(INIT),
                 .DEBOUNCE_CYCLES(DB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .dir_i(dir),
    .pwm_o(pwm_o), .duty_o(duty_o));

  pwm_step_gen u_def (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(1'b0), .dir_i(1'b0),
    .pwm_o(def_pwm), .duty_o(def_duty));

  // Behavioural reference: integers only
  int m_r1 = 0, m_r2 = 0;
  int m_cnt = 0, m_act = INIT, m_duty = INIT, m_pwm = 0;
  int m_press = 0, m_stab = 0, m_dc = 0;
  int m_s1 = 0, m_s2 = 0, m_d1 = 0, m_d2 = 0;

  task automatic model_clear();
    m_cnt = 0; m_act = INIT; m_duty = INIT; m_pwm = 0;
    m_press = 0; m_stab = 0; m_dc = 0;
    m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      model_clear();
    end else if (m_r2 == 0) begin
      m_r2 = m_r1; m_r1 = 1;
      model_clear();
    end else begin
      m_pwm = (m_cnt < (P * m_act) / 10) ? 1 : 0;
      if (m_cnt == P - 1) begin
        m_cnt = 0; m_act = m_duty;
      end else begin
        m_cnt++;
      end
      if (m_press != 0) begin
        if (m_d2 != 0 && m_duty < 10) m_duty++;
        else if (m_d2 == 0 && m_duty > 0) m_duty--;
      end
      m_press = 0;
      if (m_s2 != m_stab) begin
        if (m_dc == DB - 1) begin
          m_stab = m_s2; m_dc = 0; m_press = m_s2;
        end else begin
          m_dc++;
        end
      end else begin
        m_dc = 0;
      end
      m_s2 = m_s1; m_s1 = int'(btn);
      m_d2 = m_d1; m_d1 = int'(dir);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    check(int'(pwm_o) == m_pwm, "R1 R8 pwm_o vs model", int'(pwm_o), m_pwm);
    check(int'(duty_o) == m_duty, "R3 R4 duty_o vs model", int'(duty_o), m_duty);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input logic up);
    @(negedge clk);
    dir = up;
    idle(4);
    btn = 1'b1;
    idle(DB + 4);
    btn = 1'b0;
    idle(DB + 4);
  endtask

  task automatic window(output int highs);
    highs = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h;
    int n;
    logic prev;
    idle(5);
    check(duty_o == 4'(INIT), "R2 reset duty", int'(duty_o), INIT);
    check(pwm_o == 1'b0, "R2 reset pwm low", int'(pwm_o), 0);
    rst_n = 1'b1;
    idle(4);
    window(h);
    check(h == (P * INIT) / 10, "R1 high time at init duty", h, (P * INIT) / 10);

    press(1'b1);
    check(duty_o == 4'd3, "R3 up step", int'(duty_o), 3);
    idle(P);
    window(h);
    check(h == (P * 3) / 10, "R1 floored high time", h, (P * 3) / 10);

    press(1'b0);
    check(duty_o == 4'd2, "R4 down step", int'(duty_o), 2);

    // Bounce: bursts shorter than the debounce window
    dir = 1'b1;
    idle(4);
    for (int k = 0; k < 6; k++) begin
      btn = 1'b1; idle(3);
      btn = 1'b0; idle(2);
    end
    idle(DB + 4);
    check(duty_o == 4'd2, "R6 bounce ignored", int'(duty_o), 2);

    // Long hold gives one step
    btn = 1'b1;
    idle(DB * 5);
    check(duty_o == 4'd3, "R7 single step while held", int'(duty_o), 3);
    btn = 1'b0;
    idle(DB * 3);
    check(duty_o == 4'd3, "R7 no step on release", int'(duty_o), 3);

    for (int k = 0; k < 9; k++) press(1'b1);
    check(duty_o == 4'd10, "R5 top saturation", int'(duty_o), 10);
    idle(P);
    window(h);
    check(h == P, "R5 full high period", h, P);

    for (int k = 0; k < 12; k++) press(1'b0);
    check(duty_o == 4'd0, "R5 bottom saturation", int'(duty_o), 0);
    idle(P);
    window(h);
    check(h == 0, "R5 full low period", h, 0);

    // Default-parameter instance: one full period between rising edges
    prev = def_pwm;
    forever begin
      @(negedge clk);
      if (def_pwm && !prev) break;
      prev = def_pwm;
    end
    n = 1; h = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (def_pwm && !prev) break;
      prev = def_pwm;
      n++;
      if (def_pwm) h++;
    end
    check(n == 50000, "R9 default period", n, 50000);
    check(h == 10000, "R9 default high time", h, 10000);
    check(def_duty == 4'd2, "R9 default duty setting", int'(def_duty), 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule